// File: doc/BRIEF.md
# DRAM Refresh and Wake-Up Sequencer

This block owns the refresh duties of an asynchronous EDO DRAM that sits behind a separate access controller. After reset it keeps every strobe inactive through a programmable start-up pause. It then runs a fixed number of wake-up cycles, each with a full RAS pulse, and after those it signals that the memory is usable. From then on an interval timer marks a refresh as due at a fixed rate. The block asks the access controller for the bus and issues CAS-before-RAS refresh cycles while the grant is held.

Every refresh and wake-up cycle uses CAS-before-RAS ordering. The device supplies the row from its own counter, so the address bus is left to the access controller and is not driven here. WE and OE stay inactive, so the data pins remain high-impedance. Refreshes that fall due while the bus is withheld are counted. Once the grant arrives they are issued back to back with only the precharge time between them. If the backlog counter is full and yet another refresh falls due, the interval is taken as violated. The block then drops its ready flag and reruns the wake-up sequence.

All times are given in clock cycles through parameters: the pause, the refresh interval, the CAS lead before RAS, the RAS low width, the CAS hold after RAS falls, the precharge time, the number of wake-up cycles and the depth of the backlog.

Top module: `dram_rfsh_seq`

## Requirements
- R1: From reset until PAUSE_CYC clock edges have passed, RAS, LCAS, UCAS stay high and the request and ready outputs stay low; the request rises in the cycle after edge PAUSE_CYC.
- R2: After the pause exactly WAKE_CNT strobe cycles are issued with ready low. Ready rises T_RP cycles after RAS rises at the end of the last of them.
- R3: Each cycle drives LCAS and UCAS low together T_CSR cycles before RAS falls, and returns them high after T_CHR cycles with RAS low.
- R4: RAS stays low for exactly T_RAS cycles in every cycle.
- R5: After RAS rises, RAS and CAS stay high for at least T_RP cycles before CAS falls again.
- R6: WE and OE are held high (inactive) at all times.
- R7: Once ready, a refresh falls due every INTERVAL_CYC cycles, the first INTERVAL_CYC cycles after ready rises. The request rises when a refresh is due and the bus is idle.
- R8: A cycle starts only at a clock edge where the grant input is high. With the grant low, no strobe moves.
- R9: Up to PEND_MAX due refreshes are retained while the grant is low. When the grant is given, they are issued back to back with exactly T_RP cycles of precharge between them.
- R10: If a refresh falls due while PEND_MAX are already outstanding, ready falls at that edge and the backlog is discarded. The block then requests the bus and reruns WAKE_CNT wake-up cycles before ready rises again.
- R11: The request is high during every cycle in which a strobe is low, and falls once no work remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rf_gnt_i | input | 1 | Bus grant from the access controller |
| rf_req_o | output | 1 | Bus request for refresh or wake-up work |
| ready_o | output | 1 | Wake-up sequence complete, memory usable |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower byte column strobe, active low |
| ucas_n_o | output | 1 | Upper byte column strobe, active low |
| we_n_o | output | 1 | Write enable, active low, held inactive |
| oe_n_o | output | 1 | Output enable, active low, held inactive |

## Verification
The assertions assume that the access controller changes the grant only between clock edges. They also assume that a grant, once given, belongs to this block until the request drops. The grant is the only input the checks relate to the strobes. The bench changes the grant shortly after a rising edge and never inside a cycle it has granted. It lowers the grant only after the request has fallen. It raises the grant only at times it works out from the interval, so every backlog stays within the bound that the scenario under test intends.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } rfsh_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int unsigned INTERVAL_CYC = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned W = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;

  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/rfsh_pend_ctr.sv
module rfsh_pend_ctr #(
  parameter int unsigned PEND_MAX = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic nz_o,
  output logic overrun_o
);
  localparam int unsigned PW = $clog2(PEND_MAX + 1);

  logic [PW-1:0] pend_q;

  assign nz_o      = (pend_q != '0);
  assign overrun_o = tick_i && !take_i && (pend_q == PW'(PEND_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pend_q <= '0;
    else if (overrun_o)          pend_q <= '0;
    else if (tick_i && !take_i)  pend_q <= pend_q + 1'b1;
    else if (!tick_i && take_i)  pend_q <= pend_q - 1'b1;
  end

  // R9
  pend_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PW'(PEND_MAX));

  // R9
  take_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> nz_o);
endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
  import rfsh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 10000,
  parameter int unsigned WAKE_CNT  = 8,
  parameter int unsigned T_CSR     = 1,
  parameter int unsigned T_RAS     = 4,
  parameter int unsigned T_CHR     = 2,
  parameter int unsigned T_RP      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gnt_i,
  input  logic pend_nz_i,
  input  logic overrun_i,
  output logic take_o,
  output logic ready_o,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned CMAX = max_u(max_u(PAUSE_CYC, T_RAS), max_u(T_RP, T_CSR));
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned KW   = $clog2(WAKE_CNT + 1);

  rfsh_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [KW-1:0] wake_q, wake_d;
  logic          ready_q, ready_d;
  logic          work, pre_end, wake_fin, go;

  always_comb begin
    work     = ready_q ? pend_nz_i : 1'b1;
    pre_end  = (state_q == ST_PRE) && (cnt_q == CW'(T_RP - 1));
    wake_fin = pre_end && !ready_q && (wake_q == KW'(WAKE_CNT - 1));
    go       = 1'b0;
    state_d  = state_q;
    cnt_d    = cnt_q + 1'b1;
    unique case (state_q)
      ST_PAUSE: if (cnt_q == CW'(PAUSE_CYC - 1)) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (work && gnt_i) begin
          state_d = ST_CAS;
          go      = 1'b1;
        end
      end
      ST_CAS: if (cnt_q == CW'(T_CSR - 1)) begin
        state_d = ST_RAS;
        cnt_d   = '0;
      end
      ST_RAS: if (cnt_q == CW'(T_RAS - 1)) begin
        state_d = ST_PRE;
        cnt_d   = '0;
      end
      ST_PRE: if (pre_end) begin
        cnt_d = '0;
        // back to back when more work is waiting and the bus is still ours
        if (work && gnt_i && !wake_fin) begin
          state_d = ST_CAS;
          go      = 1'b1;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_comb begin
    ready_d = ready_q;
    wake_d  = wake_q;
    if (overrun_i) begin
      ready_d = 1'b0;
      wake_d  = '0;
    end else if (pre_end && !ready_q) begin
      wake_d = wake_q + 1'b1;
      if (wake_fin) ready_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      cnt_q   <= '0;
      wake_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wake_q  <= wake_d;
      ready_q <= ready_d;
    end
  end

  assign take_o  = go && ready_q;
  assign ready_o = ready_q;
  assign req_o   = (state_q != ST_PAUSE) && ((state_q != ST_IDLE) || work);
  assign ras_n_o = (state_q != ST_RAS);
  assign cas_n_o = !((state_q == ST_CAS) ||
                     ((state_q == ST_RAS) && (cnt_q < CW'(T_CHR))));

  // run-length monitors for the strobe checks
  logic [CW-1:0] lo_run_q, hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run_q <= '0;
      hi_run_q <= '0;
    end else begin
      lo_run_q <= ras_n_o ? '0 : lo_run_q + 1'b1;
      if (!ras_n_o || !cas_n_o)             hi_run_q <= '0;
      else if (hi_run_q != CW'(T_RP))       hi_run_q <= hi_run_q + 1'b1;
    end
  end

  // R4
  ras_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_run_q == CW'(T_RAS)));

  // R5
  precharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> (hi_run_q == CW'(T_RP)));

  // R3
  cbr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  // R8
  grant_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(gnt_i));
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq #(
  parameter int unsigned PAUSE_CYC    = 10000,
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = 780,
  parameter int unsigned PEND_MAX     = 8,
  parameter int unsigned T_CSR        = 1,
  parameter int unsigned T_RAS        = 4,
  parameter int unsigned T_CHR        = 2,
  parameter int unsigned T_RP         = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rf_gnt_i,
  output logic rf_req_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic we_n_o,
  output logic oe_n_o
);
  logic tick, take, pend_nz, overrun, cas_n;

  rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ready_o),
    .tick_o (tick)
  );

  rfsh_pend_ctr #(.PEND_MAX(PEND_MAX)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .take_i    (take),
    .nz_o      (pend_nz),
    .overrun_o (overrun)
  );

  rfsh_cycle_fsm #(
    .PAUSE_CYC (PAUSE_CYC),
    .WAKE_CNT  (WAKE_CNT),
    .T_CSR     (T_CSR),
    .T_RAS     (T_RAS),
    .T_CHR     (T_CHR),
    .T_RP      (T_RP)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gnt_i     (rf_gnt_i),
    .pend_nz_i (pend_nz),
    .overrun_i (overrun),
    .take_o    (take),
    .ready_o   (ready_o),
    .req_o     (rf_req_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n)
  );

  assign lcas_n_o = cas_n;
  assign ucas_n_o = cas_n;
  // refresh only: no write, outputs kept high-impedance
  assign we_n_o   = 1'b1;
  assign oe_n_o   = 1'b1;

  // R10
  overrun_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun |=> (!ready_o && rf_req_o));

  // R11
  req_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !lcas_n_o) |-> rf_req_o);
endmodule

// File: tb/dram_rfsh_seq_tb.sv
module dram_rfsh_seq_tb;
  timeunit 1ns;
  timeprecision 1ns;

  localparam int PAUSE = 20;
  localparam int WAKE  = 8;
  localparam int INTV  = 60;
  localparam int PMAX  = 4;
  localparam int CSR   = 1;
  localparam int RASW  = 4;
  localparam int CHR   = 2;
  localparam int RP    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gnt = 1'b0;
  logic req, ready, ras_n, lcas_n, ucas_n, we_n, oe_n;

  always #10 clk = ~clk;

  dram_rfsh_seq #(
    .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(INTV), .PEND_MAX(PMAX),
    .T_CSR(CSR), .T_RAS(RASW), .T_CHR(CHR), .T_RP(RP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rf_gnt_i(gnt), .rf_req_o(req), .ready_o(ready),
    .ras_n_o(ras_n), .lcas_n_o(lcas_n), .ucas_n_o(ucas_n), .we_n_o(we_n), .oe_n_o(oe_n)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard of expected RAS pulses
  bit    q_rdy[$];
  int    q_gap[$];
  string q_tag[$];

  task automatic expect_pulse(input bit rdy, input int gap, input string tag);
    q_rdy.push_back(rdy);
    q_gap.push_back(gap);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // monitor
  bit p_ras = 1'b1, p_cas = 1'b1, p_gnt = 1'b0, rdy_fall = 1'b0;
  int cas_lead = 0, ras_lo = 0, chr_cnt = 0, hi_cnt = 0, gap_meas = 0, last_rise = 0;
  int byte_err = 0, pin_err = 0, req_err = 0, grant_err = 0;

  always @(negedge clk) if (rst_n) begin
    bit r, c, e_rdy;
    int e_gap;
    string e_tag;
    r = ras_n;
    c = lcas_n;
    if (lcas_n !== ucas_n) byte_err++;
    if (we_n !== 1'b1 || oe_n !== 1'b1) pin_err++;
    if ((!r || !c) && !req) req_err++;
    if (p_cas && !c) begin
      gap_meas = hi_cnt;
      if (!p_gnt) grant_err++;
    end
    if (!c && r) cas_lead++;
    if (p_ras && !r) rdy_fall = ready;
    if (!r) begin
      ras_lo++;
      if (!c) chr_cnt++;
    end
    if (!p_ras && r) begin
      if (q_rdy.size() == 0) begin
        chk(1'b0, "R8 unexpected RAS pulse", 1, 0);
      end else begin
        e_rdy = q_rdy.pop_front();
        e_gap = q_gap.pop_front();
        e_tag = q_tag.pop_front();
        chk(cas_lead == CSR, {e_tag, " R3 CAS lead"}, cas_lead, CSR);
        chk(chr_cnt == CHR, {e_tag, " R3 CAS hold"}, chr_cnt, CHR);
        chk(ras_lo == RASW, {e_tag, " R4 RAS width"}, ras_lo, RASW);
        chk(rdy_fall == e_rdy, {e_tag, " ready level"}, int'(rdy_fall), int'(e_rdy));
        if (e_gap > 0) chk(gap_meas == e_gap, {e_tag, " R5 precharge gap"}, gap_meas, e_gap);
      end
      cas_lead = 0; ras_lo = 0; chr_cnt = 0; hi_cnt = 0;
      last_rise = cyc;
    end
    if (r && c) hi_cnt++;
    p_ras = r; p_cas = c; p_gnt = gnt;
  end

  task automatic drive_gnt(input bit v);
    @(posedge clk);
    #5 gnt = v;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int cyc_r, cyc_r2, guard, pause_err;
    gnt = 1'b1; // grant offered during the pause: must be ignored (R1)
    for (int i = 0; i < WAKE; i++) expect_pulse(1'b0, (i == 0) ? 0 : RP, "R2");
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk(ras_n && lcas_n && ucas_n, "R1 strobes high in reset", int'(ras_n && lcas_n), 1);
    chk(!req && !ready, "R1 req/ready low in reset", int'(req || ready), 0);
    @(posedge clk);
    #5 rst_n = 1'b1;

    pause_err = 0;
    guard = 0;
    @(negedge clk);
    while (!req && guard < 1000) begin
      if (!ras_n || !lcas_n || ready) pause_err++;
      guard++;
      @(negedge clk);
    end
    chk(pause_err == 0, "R1 quiet during pause", pause_err, 0);
    chk(cyc == PAUSE, "R1 request after pause", cyc, PAUSE);

    guard = 0;
    while (!ready && guard < 2000) begin guard++; @(negedge clk); end
    cyc_r = cyc;
    chk(ready, "R2 ready rises", int'(ready), 1);
    chk(cyc_r - last_rise == RP, "R2 ready after last precharge", cyc_r - last_rise, RP);
    chk(q_rdy.size() == 0, "R2 wake cycle count", q_rdy.size(), 0);
    chk(!req, "R11 request drops with no work", int'(req), 0);
    drive_gnt(1'b0);

    // R7 refresh interval
    wait_until(cyc_r + INTV - 1);
    chk(!req, "R7 no request before interval", int'(req), 0);
    wait_until(cyc_r + INTV);
    chk(req, "R7 request at interval", int'(req), 1);

    // R8: grant withheld over three intervals, nothing may move
    wait_until(cyc_r + 3 * INTV);
    chk(req && ready, "R8 waiting for grant", int'(req && ready), 1);
    expect_pulse(1'b1, 0, "R9");
    expect_pulse(1'b1, RP, "R9");
    expect_pulse(1'b1, RP, "R9");
    drive_gnt(1'b1);
    wait_until(cyc_r + 3 * INTV + 40);
    chk(q_rdy.size() == 0, "R9 backlog of three issued", q_rdy.size(), 0);
    chk(!req, "R11 request drops after backlog", int'(req), 0);
    drive_gnt(1'b0);

    // R9 full backlog of PMAX
    wait_until(cyc_r + 7 * INTV);
    for (int i = 0; i < PMAX; i++) expect_pulse(1'b1, (i == 0) ? 0 : RP, "R9");
    drive_gnt(1'b1);
    wait_until(cyc_r + 7 * INTV + 40);
    chk(q_rdy.size() == 0, "R9 full backlog issued", q_rdy.size(), 0);
    chk(ready, "R9 ready kept at full backlog", int'(ready), 1);
    drive_gnt(1'b0);

    // R10 overrun on the fifth outstanding refresh
    wait_until(cyc_r + 12 * INTV - 1);
    chk(ready, "R10 ready before overrun", int'(ready), 1);
    wait_until(cyc_r + 12 * INTV);
    chk(!ready, "R10 ready falls at overrun", int'(ready), 0);
    chk(req, "R10 requests bus for wake-up", int'(req), 1);
    wait_until(cyc_r + 12 * INTV + 10);
    chk(!ready && ras_n, "R10 idle until granted", int'(ready || !ras_n), 0);
    for (int i = 0; i < WAKE; i++) expect_pulse(1'b0, (i == 0) ? 0 : RP, "R10");
    drive_gnt(1'b1);
    guard = 0;
    while (!ready && guard < 2000) begin guard++; @(negedge clk); end
    cyc_r2 = cyc;
    chk(q_rdy.size() == 0, "R10 wake-up rerun count", q_rdy.size(), 0);
    chk(cyc_r2 - last_rise == RP, "R10 ready after rerun", cyc_r2 - last_rise, RP);
    drive_gnt(1'b0);

    wait_until(cyc_r2 + INTV - 1);
    chk(!req, "R7 timer restarted", int'(req), 0);
    wait_until(cyc_r2 + INTV);
    chk(req, "R7 first due after rerun", int'(req), 1);
    expect_pulse(1'b1, 0, "R7");
    drive_gnt(1'b1);
    wait_until(cyc_r2 + INTV + 20);
    chk(q_rdy.size() == 0, "R7 single refresh issued", q_rdy.size(), 0);
    drive_gnt(1'b0);
    @(negedge clk);

    chk(byte_err == 0, "R3 byte strobes move together", byte_err, 0);
    chk(pin_err == 0, "R6 WE/OE held high", pin_err, 0);
    chk(req_err == 0, "R11 request covers strobes", req_err, 0);
    chk(grant_err == 0, "R8 start only under grant", grant_err, 0);
    finish_run();
  end
endmodule